// File: doc/BRIEF.md
# Timer Count-Source Selector with Divide-by-13 Prescaler

This block decides, for each of two general-purpose timers in an 8051-style microcontroller, which event advances the timer. The classic choice is either a tick every 12 oscillator cycles (timer mode) or a falling edge on an external count pin (counter mode). For each timer there is also its own override bit. When set, the override replaces that input with a tick every 13 oscillator cycles. A 13-cycle base runs at 12/13 of the classic rate. For example, a 12 MHz oscillator then behaves like an 11.0769 MHz one, about 0.16% away from the usual 11.0592 MHz serial-rate crystal.

The override on the first timer applies in every operating mode. The second timer has a baud-generator flag, and while that flag is high its override bit is disregarded: the timer falls back to the pin or the 12-cycle tick, as its mode bit selects. The block emits one single-cycle count-enable strobe per timer. The counting logic itself sits downstream. The external pins are asynchronous and pass through a two-flop synchronizer before edge detection. The control bits are staged in a register that reset clears.

Top module: `tmr_src_div13`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, both strobes are low. Reset clears the staged control bits and restarts both prescaler counters.
- R2: The 13-cycle prescaler counts 0..12 and wraps. With an override active and the controls held since reset, the strobe is high after clock edges 13, 26, 39, ... counted from the first edge with reset low.
- R3: The two override bits are independent: setting one never changes the other timer's source.
- R4: For timer 0, an active override selects the 13-cycle tick regardless of its mode bit.
- R5: For timer 1 with the baud flag low, an active override selects the 13-cycle tick regardless of its mode bit.
- R6: For timer 1 with the baud flag high, the override bit has no effect, and the source follows the mode bit as in R7 and R8.
- R7: With no active override and the mode bit low (timer mode), the strobe is high after edges 12, 24, 36, ... counted from the first edge with reset low.
- R8: With no active override and the mode bit high (counter mode), the strobe is high after edge m exactly when the pin was sampled high at edge m-3 and low at edge m-2.
- R9: Override, mode and baud bits take effect through one staging register. The strobe after edge m follows the control values sampled at edge m-1.
- R10: Each strobe pulse is one cycle wide. Under a fixed configuration no two consecutive cycles carry a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_pin_i | input | 2 | External count pins, one per timer, asynchronous |
| div13_en_i | input | 2 | Per-timer divide-by-13 override bit |
| cnt_mode_i | input | 2 | Per-timer mode bit: 1 counts pin edges, 0 counts 12-cycle ticks |
| t1_baud_i | input | 1 | Timer 1 baud-generator mode flag, exempts timer 1 from its override |
| cnt_strobe_o | output | 2 | Per-timer single-cycle count-enable strobe |

## Verification
The assertions assume that the override, mode and baud bits are synchronous to the clock, and that each strobe is attributed to the source the staged controls named one cycle earlier. The count pins may change at any time, because they pass through the synchronizer. The stimulus changes the control bits only between clock edges, at the falling edge, and holds them steady during the directed windows where pulse width is checked. The pins are toggled randomly, including in consecutive cycles, so that back-to-back edges reach the edge detector.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    localparam int NUM_TMR     = 2;
    localparam int BAUD_IDX    = 1;
    localparam int DIV_ALT     = 13;
    localparam int DIV_STD     = 12;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [1:0] {
        SRC_STD_TICK = 2'd0,
        SRC_PIN      = 2'd1,
        SRC_ALT_TICK = 2'd2
    } src_e;

    typedef struct packed {
        logic alt_en;
        logic cnt_mode;
        logic baud_exempt;
    } tmr_ctrl_t;

    function automatic src_e pick_src(tmr_ctrl_t c);
        if (c.alt_en && !c.baud_exempt) return SRC_ALT_TICK;
        else if (c.cnt_mode)            return SRC_PIN;
        else                            return SRC_STD_TICK;
    endfunction

endpackage

// File: rtl/tsd_modulo_tick.sv
module tsd_modulo_tick #(
    parameter int MOD = 13
) (
    input  logic clk,
    input  logic rst,
    output logic tick_o
);
    localparam int W = (MOD > 2) ? $clog2(MOD) : 1;
    localparam logic [W-1:0] LAST = W'(MOD - 1);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)               cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    assign tick_o = (cnt_q == LAST);

    // R2: counter never leaves its modulus range
    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R2: after a wrap the count restarts from zero
    assert_wrap_zero_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> (cnt_q == '0));

    // R10: tick is a single-cycle pulse
    assert_tick_single_R10: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);

endmodule

// File: rtl/tsd_pin_fall.sv
module tsd_pin_fall #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q[0] <= 1'b1;
        else     sh_q[0] <= pin_i;
    end

    for (genvar s = 1; s <= STAGES; s++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) sh_q[s] <= 1'b1;
            else     sh_q[s] <= sh_q[s-1];
        end
    end

    assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

    // R8: a falling edge cannot be reported in two consecutive cycles
    assert_fall_single_R8: assert property (@(posedge clk) disable iff (rst)
        fall_o |=> !fall_o);

endmodule

// File: rtl/tsd_src_select.sv
module tsd_src_select
    import tsd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  tmr_ctrl_t ctrl_i,
    input  logic      alt_tick_i,
    input  logic      std_tick_i,
    input  logic      pin_fall_i,
    output logic      strobe_o
);
    tmr_ctrl_t ctrl_q;
    src_e      src;
    logic      strobe_d;

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_i;
    end

    always_comb begin
        src = pick_src(ctrl_q);
        unique case (src)
            SRC_ALT_TICK: strobe_d = alt_tick_i;
            SRC_PIN:      strobe_d = pin_fall_i;
            default:      strobe_d = std_tick_i;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) strobe_o <= 1'b0;
        else     strobe_o <= strobe_d;
    end

    // R4/R5: with override active the strobe stems only from the 13-cycle tick
    assert_alt_source_R5: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(ctrl_q.alt_en && !ctrl_q.baud_exempt)) |-> $past(alt_tick_i));

    // R6: exempt timer in timer mode uses the 12-cycle tick despite the override
    assert_baud_exempt_R6: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(ctrl_q.baud_exempt && !ctrl_q.cnt_mode)) |-> $past(std_tick_i));

    // R8: counter mode without override follows the pin edge detector
    assert_pin_path_R8: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(!(ctrl_q.alt_en && !ctrl_q.baud_exempt) && ctrl_q.cnt_mode))
            |-> $past(pin_fall_i));

    // R7: timer mode without override follows the 12-cycle tick
    assert_std_path_R7: assert property (@(posedge clk) disable iff (rst)
        (strobe_o && $past(!(ctrl_q.alt_en && !ctrl_q.baud_exempt) && !ctrl_q.cnt_mode))
            |-> $past(std_tick_i));

endmodule

// File: rtl/tmr_src_div13.sv
module tmr_src_div13
    import tsd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_TMR-1:0] cnt_pin_i,
    input  logic [NUM_TMR-1:0] div13_en_i,
    input  logic [NUM_TMR-1:0] cnt_mode_i,
    input  logic               t1_baud_i,
    output logic [NUM_TMR-1:0] cnt_strobe_o
);
    logic alt_tick;
    logic std_tick;

    tsd_modulo_tick #(.MOD(DIV_ALT)) u_alt_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (alt_tick)
    );

    tsd_modulo_tick #(.MOD(DIV_STD)) u_std_tick (
        .clk    (clk),
        .rst    (rst),
        .tick_o (std_tick)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
        tmr_ctrl_t ctrl;
        logic      pin_fall;

        assign ctrl.alt_en   = div13_en_i[i];
        assign ctrl.cnt_mode = cnt_mode_i[i];
        if (i == BAUD_IDX) begin : g_exempt
            assign ctrl.baud_exempt = t1_baud_i;
        end else begin : g_plain
            assign ctrl.baud_exempt = 1'b0;
        end

        tsd_pin_fall #(.STAGES(SYNC_STAGES)) u_pin (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (cnt_pin_i[i]),
            .fall_o (pin_fall)
        );

        tsd_src_select u_sel (
            .clk        (clk),
            .rst        (rst),
            .ctrl_i     (ctrl),
            .alt_tick_i (alt_tick),
            .std_tick_i (std_tick),
            .pin_fall_i (pin_fall),
            .strobe_o   (cnt_strobe_o[i])
        );
    end

    // R1: strobes stay low in the cycle right after reset
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (cnt_strobe_o == '0));

endmodule

// File: tb/tmr_src_div13_bench.sv
`timescale 1ns/1ps
module tmr_src_div13_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pin = 2'b11;
    logic [1:0] en  = 2'b00;
    logic [1:0] md  = 2'b00;
    logic       baud = 1'b0;
    logic [1:0] strb;

    int checks = 0;
    int errors = 0;
    int m = 0;
    bit done = 0;

    logic [1:0] p0, p1, p2, p3;
    logic [1:0] pen, pmd;
    logic       pbd;
    logic [1:0] last_strb;

    always #2.5 clk = ~clk;

    tmr_src_div13 u_tmr_src_div13 (
        .clk          (clk),
        .rst          (rst),
        .cnt_pin_i    (pin),
        .div13_en_i   (en),
        .cnt_mode_i   (md),
        .t1_baud_i    (baud),
        .cnt_strobe_o (strb)
    );

    function automatic logic alt_active(int i);
        return pen[i] && !(i == 1 && pbd);
    endfunction

    function automatic logic exp_strobe(int i);
        int e = m - 1;
        logic t13 = (e >= 1) && (e % 13 == 12);
        logic t12 = (e >= 1) && (e % 12 == 11);
        logic fl  = p3[i] & ~p2[i];
        if (alt_active(i)) return t13;
        else if (pmd[i])   return fl;
        else               return t12;
    endfunction

    function automatic string path_tag(int i);
        if (alt_active(i))            return (i == 0) ? "R4" : "R5";
        else if (i == 1 && pbd && pen[1]) return "R6";
        else if (pmd[i])              return "R8";
        else                          return "R7";
    endfunction

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk);
            @(negedge clk);
            checks++;
            if (strb !== 2'b00) begin
                errors++;
                $display("FAIL R1 reset cycle %0d actual %b expected 00", k, strb);
            end
        end
        m = 0; p0 = 2'b11; p1 = 2'b11; p2 = 2'b11; p3 = 2'b11;
        pen = 2'b00; pmd = 2'b00; pbd = 1'b0; last_strb = 2'b00;
        rst = 1'b0;
    endtask

    task automatic step(input logic [1:0] p, input logic [1:0] e, input logic [1:0] d,
                        input logic b, input string tag, input bit width_chk);
        logic [1:0] ex;
        pin = p; en = e; md = d; baud = b;
        @(posedge clk);
        m++;
        p3 = p2; p2 = p1; p1 = p0; p0 = p;
        @(negedge clk);
        for (int i = 0; i < 2; i++) begin
            ex[i] = exp_strobe(i);
            checks++;
            if (strb[i] !== ex[i]) begin
                errors++;
                $display("FAIL %s/%s timer %0d cycle %0d actual %b expected %b",
                         tag, path_tag(i), i, m, strb[i], ex[i]);
            end
            if (width_chk) begin
                checks++;
                if (strb[i] && last_strb[i]) begin
                    errors++;
                    $display("FAIL R10 timer %0d cycle %0d actual 11 expected not both high", i, m);
                end
            end
        end
        last_strb = strb;
        pen = e; pmd = d; pbd = b;
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired cycle %0d actual hung expected finish", m);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [1:0] rp, re, rd;
        logic rb;
        void'($urandom(32'h1357_9BDF));
        @(negedge clk);
        do_reset(3);

        // R2: both overrides from reset, timer mode; first strobe at edge 13
        for (int k = 0; k < 60; k++) step(2'b11, 2'b11, 2'b00, 1'b0, "R2", 1);

        // R3: override only on timer 0, timer 1 counts random pin edges
        for (int k = 0; k < 80; k++) step(2'($urandom), 2'b01, 2'b11, 1'b0, "R3", 1);

        // R5: override on timer 1 in counter mode, baud flag low
        for (int k = 0; k < 60; k++) step(2'($urandom), 2'b10, 2'b11, 1'b0, "R5", 1);

        // R4: override on timer 0 in counter mode
        for (int k = 0; k < 60; k++) step(2'($urandom), 2'b11, 2'b01, 1'b0, "R4", 1);

        // R6: baud flag high, timer 1 override ignored (counter then timer mode)
        for (int k = 0; k < 60; k++) step(2'($urandom), 2'b11, 2'b10, 1'b1, "R6", 0);
        for (int k = 0; k < 60; k++) step(2'($urandom), 2'b11, 2'b00, 1'b1, "R6", 0);

        // R7: no override, timer mode
        for (int k = 0; k < 50; k++) step(2'($urandom), 2'b00, 2'b00, 1'b0, "R7", 0);

        // R8: no override, counter mode; slow and fast pin activity
        for (int k = 0; k < 40; k++) step((k % 6 < 3) ? 2'b11 : 2'b00, 2'b00, 2'b11, 1'b0, "R8", 1);
        for (int k = 0; k < 40; k++) step(2'($urandom), 2'b00, 2'b11, 1'b0, "R8", 1);

        // R1: reset mid-run with overrides requested restarts the prescaler
        do_reset(2);
        for (int k = 0; k < 30; k++) step(2'b11, 2'b11, 2'b00, 1'b0, "R1", 1);

        // R9: toggle override every few cycles to observe one-cycle staging
        for (int k = 0; k < 120; k++)
            step(2'($urandom), ((k / 5) % 2 == 0) ? 2'b11 : 2'b00, 2'b00, 1'b0, "R9", 0);

        // constrained random: controls change occasionally, pins freely
        rp = 2'b11; re = 2'b00; rd = 2'b00; rb = 1'b0;
        for (int k = 0; k < 3000; k++) begin
            if ($urandom_range(0, 3) == 0) rp = 2'($urandom);
            if ($urandom_range(0, 19) == 0) begin
                re = 2'($urandom); rd = 2'($urandom); rb = 1'($urandom);
            end
            step(rp, re, rd, rb, "RND", 0);
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule